// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog timer that shares one scaler counter with a general-purpose timer. The scaler serves one owner at a time. It either divides the timer's clock pulses before they reach the timer counter, or it divides the watchdog's overflow pulses to stretch the time-out period. A small option register holds the owner bit and a select field. The select field picks one of the scaler's taps, which gives divide ratios from 1:1 up to 1:2^(taps-1).

The watchdog advances on a single-cycle tick-enable input, and only while its enable input is high. The block also handles the core's sleep and clear-watchdog strobes, and it keeps the power-down and time-out status flags. A time-out while the core is awake raises a one-cycle internal reset. That reset returns the block to its reset state, except for the flags. A time-out while the core sleeps raises a one-cycle wake pulse instead. The timer counter, the oscillator and the core are outside the block. The internal reset output is meant for the chip's internal reset tree only and never drives the external reset pin.

Top module: `wdog_shared_scaler`

## Requirements
- R1: After `rst_n`:
  - `pd_flag` and `to_flag` are 1.
  - `wdt_reset`, `wake_pulse` and `tmr_tick` are 0.
  - The option register holds all ones: owner bit 1 (watchdog) and select 7. With ticks every cycle and WDT_W=3, the first time-out therefore comes 1024 ticks after reset.
- R2: While `wdt_en` is 0, the watchdog never times out, so `wdt_reset` and `wake_pulse` stay 0.
- R3: With owner bit 0 (scaler given to the timer), a time-out follows the 2^WDT_W-th enabled tick after the watchdog was last cleared.
- R4: With owner bit 1 and select k, a time-out follows 2^WDT_W * 2^k enabled ticks.
- R5: `tmr_tick` follows `tmr_clk_en` by one cycle.
  - With owner bit 0 and select k, it fires once for every 2^k timer pulses.
  - With owner bit 1, it follows every timer pulse.
- R6: A `sleep_cmd` strobe has these effects:
  - It clears the watchdog counter, and also the scaler when the watchdog owns it.
  - It clears `pd_flag` and sets `to_flag`.
  - It puts the block in the sleep state.
- R7: A `clrwdt_cmd` strobe has these effects:
  - It clears the watchdog counter, and also the scaler when the watchdog owns it.
  - It sets `pd_flag` and `to_flag`.
  - It takes priority over a `sleep_cmd` in the same cycle.
  - It takes priority over an overflow that would have happened in the same cycle.
- R8: A time-out while awake has these effects:
  - `wdt_reset` pulses for exactly one cycle.
  - `to_flag` is cleared and `pd_flag` is set.
  - In the following cycle, the option register reloads all ones and both counters clear.
- R9: A time-out while asleep has these effects:
  - `wake_pulse` pulses for exactly one cycle instead of a reset.
  - `to_flag` is cleared and `pd_flag` stays 0.
  - The block leaves the sleep state, so the next time-out is a reset.
- R10: An option write (`opt_we`) stores `opt_wdata`, with bit 3 as the owner bit and bits 2:0 as the select field.
  - A write that changes the owner bit clears the scaler.
  - A write that keeps the owner bit leaves the scaler's partial count intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (any reset source) |
| wdt_en | input | 1 | Watchdog enable from configuration |
| wdt_tick | input | 1 | Watchdog base tick enable, one cycle per tick |
| tmr_clk_en | input | 1 | Timer clock pulse, one cycle per pulse |
| opt_wdata | input | SEL_W+1 (4) | Option write data: owner bit on top, select field below |
| opt_we | input | 1 | Option register write strobe |
| sleep_cmd | input | 1 | Sleep entry strobe |
| clrwdt_cmd | input | 1 | Clear-watchdog strobe |
| wdt_reset | output | 1 | One-cycle internal reset on an awake time-out |
| wake_pulse | output | 1 | One-cycle wake request on a time-out during sleep |
| tmr_tick | output | 1 | Scaled or direct clock pulse for the timer counter |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Time-out status flag |

## Verification
The bench builds the block with WDT_W=3, which shortens the base watchdog period to eight ticks. SCALER_W keeps its default of 8, so all eight taps exist. With these values the longest postscaled time-out is 1024 cycles, which lets the bench measure every divide ratio exactly, including the reset-default 1:128. The short base period also lets the bench place a clear strobe on the very cycle of an overflow. It can then run a sleep–wake–reset sequence end to end within a few dozen cycles.

// File: rtl/wdsc_pkg.sv
`timescale 1ns/1ps
package wdsc_pkg;

    // Sleep / status state kept by the flag logic
    typedef struct packed {
        logic asleep;
        logic pd;
        logic to;
        logic rst_pulse;
        logic wake;
    } stat_t;

    localparam stat_t STAT_RESET = '{asleep: 1'b0, pd: 1'b1, to: 1'b1,
                                     rst_pulse: 1'b0, wake: 1'b0};

endpackage

// File: rtl/wdsc_base_ctr.sv
`timescale 1ns/1ps
module wdsc_base_ctr #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic clear,
    output logic ovf
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             advance;

    always_comb begin
        advance = en && tick && !clear;
        ovf     = advance && (cnt_q == {CNT_W{1'b1}});
        cnt_d   = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (advance) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_BASE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == '0)); // R3

    AST_BASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/wdsc_scaler.sv
`timescale 1ns/1ps
module wdsc_scaler #(
    parameter int SCALER_W = 8,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic [SEL_W-1:0] sel,
    input  logic             clear,
    output logic             fire
);

    localparam int TAPS = 1 << SEL_W;

    logic [SCALER_W-1:0] cnt_d, cnt_q;
    logic [TAPS-1:0]     tap_hit;

    // Tap k fires on every 2^k-th input pulse: low k bits all ones
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam logic [SCALER_W-1:0] MASK = SCALER_W'((64'd1 << k) - 64'd1);
        assign tap_hit[k] = ((cnt_q & MASK) == MASK);
    end

    always_comb begin
        fire  = pulse_in && !clear && tap_hit[sel];
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (pulse_in) begin
            cnt_d = cnt_q + SCALER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_SCALER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0)); // R10

    AST_SEL0_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_in && !clear && sel == '0) |-> fire); // R5

endmodule

// File: rtl/wdsc_status.sv
`timescale 1ns/1ps
module wdsc_status
    import wdsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_cmd,
    input  logic clr_cmd,
    input  logic timeout,
    output logic pd_flag,
    output logic to_flag,
    output logic wdt_reset,
    output logic wake_pulse
);

    stat_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        st_d.wake      = 1'b0;
        if (st_q.rst_pulse) begin
            st_d.asleep = 1'b0;
        end else if (clr_cmd) begin
            st_d.pd = 1'b1;
            st_d.to = 1'b1;
        end else if (sleep_cmd) begin
            st_d.pd     = 1'b0;
            st_d.to     = 1'b1;
            st_d.asleep = 1'b1;
        end else if (timeout) begin
            st_d.to = 1'b0;
            if (st_q.asleep) begin
                st_d.wake   = 1'b1;
                st_d.asleep = 1'b0;
            end else begin
                st_d.rst_pulse = 1'b1;
                st_d.pd        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STAT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_flag    = st_q.pd;
    assign to_flag    = st_q.to;
    assign wdt_reset  = st_q.rst_pulse;
    assign wake_pulse = st_q.wake;

    AST_SLEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_cmd && !clr_cmd && !wdt_reset) |=> (!pd_flag && to_flag)); // R6

    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && !wdt_reset) |=> (pd_flag && to_flag)); // R7

    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> !wdt_reset); // R8

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R9

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_reset && wake_pulse)); // R9

    AST_TIMEOUT_CLEARS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_reset || wake_pulse) |-> !to_flag); // R8

    AST_WAKE_KEEPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> !pd_flag); // R9

endmodule

// File: rtl/wdog_shared_scaler.sv
`timescale 1ns/1ps
module wdog_shared_scaler #(
    parameter int SCALER_W = 8,
    parameter int WDT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wdt_en,
    input  logic                        wdt_tick,
    input  logic                        tmr_clk_en,
    input  logic [$clog2(SCALER_W):0]   opt_wdata,
    input  logic                        opt_we,
    input  logic                        sleep_cmd,
    input  logic                        clrwdt_cmd,
    output logic                        wdt_reset,
    output logic                        wake_pulse,
    output logic                        tmr_tick,
    output logic                        pd_flag,
    output logic                        to_flag
);

    localparam int SEL_W = $clog2(SCALER_W);
    localparam int OPT_W = SEL_W + 1;
    localparam int OWN_B = SEL_W;          // owner bit sits above the select field

    typedef struct packed {
        logic [OPT_W-1:0] opt;
        logic             tick;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             own_wdt;
    logic [SEL_W-1:0] sel;
    logic             cmd_any;
    logic             base_clear;
    logic             owner_flip;
    logic             scl_clear;
    logic             scl_in;
    logic             scl_fire;
    logic             base_ovf;
    logic             timeout;

    assign own_wdt = st_q.opt[OWN_B];
    assign sel     = st_q.opt[SEL_W-1:0];

    always_comb begin
        cmd_any    = clrwdt_cmd || sleep_cmd;
        base_clear = cmd_any || wdt_reset;
        owner_flip = opt_we && !wdt_reset && (opt_wdata[OWN_B] != own_wdt);
        scl_clear  = wdt_reset || owner_flip || (own_wdt && cmd_any);
        scl_in     = own_wdt ? base_ovf : tmr_clk_en;
        timeout    = own_wdt ? scl_fire : base_ovf;
    end

    wdsc_base_ctr #(
        .CNT_W (WDT_W)
    ) base_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wdt_en),
        .tick  (wdt_tick),
        .clear (base_clear),
        .ovf   (base_ovf)
    );

    wdsc_scaler #(
        .SCALER_W (SCALER_W),
        .SEL_W    (SEL_W)
    ) scaler_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (scl_in),
        .sel      (sel),
        .clear    (scl_clear),
        .fire     (scl_fire)
    );

    wdsc_status status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_cmd  (sleep_cmd),
        .clr_cmd    (clrwdt_cmd),
        .timeout    (timeout),
        .pd_flag    (pd_flag),
        .to_flag    (to_flag),
        .wdt_reset  (wdt_reset),
        .wake_pulse (wake_pulse)
    );

    always_comb begin
        st_d = st_q;
        if (wdt_reset) begin
            st_d.opt = '1;
        end else if (opt_we) begin
            st_d.opt = opt_wdata;
        end
        st_d.tick = own_wdt ? tmr_clk_en : scl_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{opt: '1, tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_tick = st_q.tick;

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wdt_en) |-> (!wdt_reset && !wake_pulse)); // R2

    AST_RESET_RELOADS_OPT: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> (st_q.opt == '1)); // R8

    AST_DIRECT_TIMER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        own_wdt |=> (tmr_tick == $past(tmr_clk_en))); // R5

    AST_NO_TICK_NO_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_clk_en |=> !tmr_tick); // R5

endmodule

// File: tb/wdog_shared_scaler_tb_top.sv
`timescale 1ns/1ps
module wdog_shared_scaler_tb_top;

    localparam int WDT_W = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wdt_en, wdt_tick, tmr_clk_en, opt_we, sleep_cmd, clrwdt_cmd;
    logic [3:0] opt_wdata;
    logic       wdt_reset, wake_pulse, tmr_tick, pd_flag, to_flag;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wdog_shared_scaler #(
        .SCALER_W (8),
        .WDT_W    (WDT_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdt_en     (wdt_en),
        .wdt_tick   (wdt_tick),
        .tmr_clk_en (tmr_clk_en),
        .opt_wdata  (opt_wdata),
        .opt_we     (opt_we),
        .sleep_cmd  (sleep_cmd),
        .clrwdt_cmd (clrwdt_cmd),
        .wdt_reset  (wdt_reset),
        .wake_pulse (wake_pulse),
        .tmr_tick   (tmr_tick),
        .pd_flag    (pd_flag),
        .to_flag    (to_flag)
    );

    // {kind(1=watchdog time-out, 0=timer interval), owner, select, expected cycles}
    localparam logic [20:0] VEC [10] = '{
        {1'b1, 1'b0, 3'd5, 16'd8},     // R3: scaler with timer, base period only
        {1'b1, 1'b1, 3'd0, 16'd8},     // R4 1:1
        {1'b1, 1'b1, 3'd1, 16'd16},    // R4 1:2
        {1'b1, 1'b1, 3'd3, 16'd64},    // R4 1:8
        {1'b1, 1'b1, 3'd6, 16'd512},   // R4 1:64
        {1'b0, 1'b0, 3'd0, 16'd1},     // R5 timer 1:1
        {1'b0, 1'b0, 3'd2, 16'd4},     // R5 timer 1:4
        {1'b0, 1'b0, 3'd5, 16'd32},    // R5 timer 1:32
        {1'b0, 1'b0, 3'd7, 16'd128},   // R5 timer 1:128
        {1'b0, 1'b1, 3'd6, 16'd1}      // R5 watchdog owns scaler: direct clock
    };

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock; inputs driven and outputs sampled 1 ns after the rising edge
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic write_opt(input logic own, input logic [2:0] sel);
        opt_we    = 1'b1;
        opt_wdata = {own, sel};
        cyc();
        opt_we    = 1'b0;
    endtask

    task automatic do_clr();
        clrwdt_cmd = 1'b1;
        cyc();
        clrwdt_cmd = 1'b0;
    endtask

    // which: 0 = wdt_reset, 1 = wake_pulse, 2 = tmr_tick. Counts other pulses too.
    task automatic wait_for(input int which, input int limit,
                            output int n, output int n_rst, output int n_wake);
        int i;
        logic hit;
        i = 0;
        n = -1;
        n_rst = 0;
        n_wake = 0;
        while (n < 0 && i < limit) begin
            i++;
            cyc();
            hit = (which == 0) ? wdt_reset : (which == 1) ? wake_pulse : tmr_tick;
            if (hit) n = i;
            if (wdt_reset) n_rst++;
            if (wake_pulse) n_wake++;
        end
    endtask

    task automatic tick_interval(output int n);
        int r, w;
        wait_for(2, 400, n, r, w);
        wait_for(2, 400, n, r, w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n, nr, nw, cnt;
        rst_n = 1'b0; wdt_en = 1'b0; wdt_tick = 1'b0; tmr_clk_en = 1'b0;
        opt_we = 1'b0; opt_wdata = '0; sleep_cmd = 1'b0; clrwdt_cmd = 1'b0;
        repeat (4) cyc();

        // R1 reset state
        check("R1 pd_flag after reset", pd_flag, 1);
        check("R1 to_flag after reset", to_flag, 1);
        check("R1 wdt_reset after reset", wdt_reset, 0);
        check("R1 wake_pulse after reset", wake_pulse, 0);
        check("R1 tmr_tick after reset", tmr_tick, 0);
        rst_n = 1'b1; wdt_en = 1'b1; wdt_tick = 1'b1;
        wait_for(0, 3000, n, nr, nw);
        check("R1 default option gives 1:128 postscale", n, 1024);
        wdt_en = 1'b0;
        cyc(); cyc();

        // Vector table: R3, R4, R5
        foreach (VEC[i]) begin
            logic [20:0] v;
            string tag;
            v = VEC[i];
            tag = v[20] ? (v[19] ? "R4 postscaled time-out" : "R3 base period")
                        : "R5 timer tick interval";
            if (v[20]) begin
                write_opt(v[19], v[18:16]);
                wdt_en = 1'b1;
                do_clr();
                wait_for(0, 3000, n, nr, nw);
                check(tag, n, int'(v[15:0]));
                wdt_en = 1'b0;
                cyc(); cyc();
            end else begin
                write_opt(v[19], v[18:16]);
                tmr_clk_en = 1'b1;
                tick_interval(n);
                check(tag, n, int'(v[15:0]));
                tmr_clk_en = 1'b0;
                cyc();
            end
        end

        // R2: disabled watchdog never times out (base period 8 would expire often)
        write_opt(1'b0, 3'd0);
        wdt_en = 1'b0;
        cnt = 0;
        for (int k = 0; k < 1500; k++) begin
            cyc();
            if (wdt_reset || wake_pulse) cnt++;
        end
        check("R2 time-outs while disabled", cnt, 0);

        // R6 / R9 / R8: sleep, wake on time-out, then awake time-out resets
        write_opt(1'b0, 3'd3);
        wdt_en = 1'b1;
        do_clr();
        cyc(); cyc();
        sleep_cmd = 1'b1;
        cyc();
        sleep_cmd = 1'b0;
        check("R6 pd_flag cleared by sleep", pd_flag, 0);
        check("R6 to_flag set by sleep", to_flag, 1);
        wait_for(1, 100, n, nr, nw);
        check("R6 sleep clears count, wake after 8 ticks", n, 8);
        check("R9 no reset while asleep", nr, 0);
        check("R9 to_flag cleared on wake", to_flag, 0);
        check("R9 pd_flag stays 0 on wake", pd_flag, 0);
        cyc();
        check("R9 wake pulse lasts one cycle", wake_pulse, 0);
        wait_for(0, 100, n, nr, nw);  // one of the 8 ticks after wake already spent
        check("R8 awake time-out is a reset", n, 7);
        check("R8 no wake pulse when awake", nw, 0);
        check("R8 pd_flag set on reset", pd_flag, 1);
        check("R8 to_flag cleared on reset", to_flag, 0);
        wdt_en = 1'b0;
        tmr_clk_en = 1'b1;
        cyc();
        check("R8 reset pulse lasts one cycle", wdt_reset, 0);
        tick_interval(n);
        check("R8 option reloaded: direct timer clock", n, 1);
        tmr_clk_en = 1'b0;
        cyc();

        // R7: clear on the overflow cycle wins; clear outranks sleep
        write_opt(1'b0, 3'd0);
        wdt_en = 1'b1;
        do_clr();
        repeat (7) cyc();
        clrwdt_cmd = 1'b1;
        cyc();
        clrwdt_cmd = 1'b0;
        check("R7 clear on overflow cycle suppresses reset", wdt_reset, 0);
        check("R7 pd_flag after clear", pd_flag, 1);
        check("R7 to_flag after clear", to_flag, 1);
        wait_for(0, 100, n, nr, nw);
        check("R7 full period after clear", n, 8);
        wdt_en = 1'b0;
        cyc(); cyc();
        write_opt(1'b0, 3'd0);
        wdt_en = 1'b1;
        clrwdt_cmd = 1'b1;
        sleep_cmd  = 1'b1;
        cyc();
        clrwdt_cmd = 1'b0;
        sleep_cmd  = 1'b0;
        check("R7 clear outranks sleep: pd_flag", pd_flag, 1);
        check("R7 clear outranks sleep: to_flag", to_flag, 1);
        wait_for(0, 100, n, nr, nw);
        check("R7 not asleep: reset follows", n, 8);
        check("R7 not asleep: no wake", nw, 0);
        wdt_en = 1'b0;
        cyc(); cyc();

        // R10: owner change clears scaler, same-owner write does not
        write_opt(1'b1, 3'd2);
        write_opt(1'b0, 3'd2);
        tmr_clk_en = 1'b1;
        cyc(); cyc();
        tmr_clk_en = 1'b0;
        write_opt(1'b1, 3'd2);
        write_opt(1'b0, 3'd2);
        tmr_clk_en = 1'b1;
        wait_for(2, 50, n, nr, nw);
        check("R10 owner change drops partial count", n, 4);
        cyc(); cyc();
        tmr_clk_en = 1'b0;
        write_opt(1'b0, 3'd2);
        tmr_clk_en = 1'b1;
        wait_for(2, 50, n, nr, nw);
        check("R10 same-owner write keeps partial count", n, 2);
        tmr_clk_en = 1'b0;
        cyc();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule